// File: doc/BRIEF.md
# Packed Sign-Bit Test Flag Unit

This execution unit takes two packed vector operands and reports, through a zero flag and a carry flag, how the sign bits of their elements overlap. Only the most significant bit of each element takes part. The opcode byte sets the element width: 32-bit lanes or 64-bit lanes. A length select limits the test to the low 128 bits or extends it to the full 256 bits. No vector register is written. The two flags are the only results.

The decoder also checks the prefix fields. If the width-promotion bit is set, the extra register specifier is not all ones, or the opcode byte is not one the unit serves, the operation raises an undefined-opcode fault and leaves the flags as they were. `in_ready` is always high, so every operation presented with `in_valid` is accepted. Its result appears one clock later together with an `out_valid` pulse.

Top module: `sign_test_unit`

## Requirements
- R1: Only bit 32k+31 of each 32-bit lane (opcode 8'h0E) or bit 64k+63 of each 64-bit lane (opcode 8'h0F) affects the flags; every other operand bit is ignored.
- R2: After a legal operation, `flag_z` is 1 exactly when no lane has its sign bit set in both `src_a` and `src_b`.
- R3: After a legal operation, `flag_c` is 1 exactly when no lane has its sign bit set in `src_b` and clear in `src_a`.
- R4: With `len_256`=0 only bits 127:0 are tested (4 or 2 lanes); with `len_256`=1 all 256 bits are tested (8 or 4 lanes).
- R5: An operation with `pfx_w`=1 gives `out_fault`=1 and leaves `flag_z` and `flag_c` unchanged.
- R6: An operation with `pfx_extra` other than 4'b1111 gives `out_fault`=1 and leaves the flags unchanged.
- R7: An opcode byte other than 8'h0E or 8'h0F gives `out_fault`=1 and leaves the flags unchanged.
- R8: `in_ready` is always 1; `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and a legal operation gives `out_fault`=0.
- R9: `flag_o`, `flag_s`, `flag_a` and `flag_p` read 0 after every non-faulting operation.
- R10: While `rst` is high, the next edge clears `out_valid`, `out_fault` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit accepts an operation (always 1) |
| src_a | input | 256 | First operand (the one that is inverted for the carry test) |
| src_b | input | 256 | Second operand |
| opcode | input | 8 | Opcode byte; 8'h0E for 32-bit lanes, 8'h0F for 64-bit lanes |
| len_256 | input | 1 | 1 tests 256 bits, 0 tests the low 128 bits |
| pfx_w | input | 1 | Width-promotion prefix bit; must be 0 |
| pfx_extra | input | 4 | Extra register specifier; must be 4'b1111 |
| out_valid | output | 1 | Result pulse |
| out_fault | output | 1 | Undefined-opcode fault for this result |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_o | output | 1 | Overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_a | output | 1 | Auxiliary carry flag |
| flag_p | output | 1 | Parity flag |

## Verification
The operand patterns are chosen so that each one separates a pair of outcomes. Overlapping signs against signs present only in the second operand tell the zero flag apart from the carry flag. Operands that set every bit except the lane sign bits show that non-sign bits are ignored. A sign bit at position 31 decoded in 64-bit mode shows that the lane width is honoured. A sign bit in the top lane, tested under both lengths, shows that the 128-bit length masks the upper half. Each fault is issued after a legal operation has left known flags, with operands that would change those flags, so a faulting update that leaks through is seen.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    localparam logic [7:0] OPC_TEST32 = 8'h0E;
    localparam logic [7:0] OPC_TEST64 = 8'h0F;
    localparam logic [3:0] EXTRA_UNUSED = 4'b1111;

    typedef enum logic {
        LANE_32 = 1'b0,
        LANE_64 = 1'b1
    } lane_e;

    typedef struct packed {
        lane_e lane;
        logic  illegal;
    } decode_t;

    typedef struct packed {
        logic z;
        logic c;
        logic o;
        logic s;
        logic a;
        logic p;
    } flags_t;

    function automatic int active_lanes(input lane_e lane, input logic wide, input int max_lanes);
        int n;
        n = (lane == LANE_32) ? max_lanes : max_lanes / 2;
        return wide ? n : n / 2;
    endfunction

endpackage

// File: rtl/sbt_decode.sv
module sbt_decode
    import sbt_pkg::*;
(
    input  logic [7:0]  opcode,
    input  logic        pfx_w,
    input  logic [3:0]  pfx_extra,
    output decode_t     dec
);
    logic known_op;

    always_comb begin
        known_op    = (opcode == OPC_TEST32) || (opcode == OPC_TEST64);
        dec.lane    = (opcode == OPC_TEST64) ? LANE_64 : LANE_32;
        dec.illegal = pfx_w || (pfx_extra != EXTRA_UNUSED) || !known_op;
    end
endmodule

// File: rtl/sbt_sign_gather.sv
module sbt_sign_gather
    import sbt_pkg::*;
#(
    parameter int DATA_W = 256
) (
    input  logic [DATA_W-1:0]        vec,
    input  lane_e                    lane,
    input  logic                     wide,
    output logic [DATA_W/32-1:0]     signs
);
    localparam int MAX_LANES = DATA_W / 32;
    localparam int DBL_LANES = MAX_LANES / 2;

    logic [MAX_LANES-1:0] s32;
    logic [MAX_LANES-1:0] s64;
    logic [MAX_LANES-1:0] keep;

    genvar i;
    generate
        for (i = 0; i < MAX_LANES; i++) begin : g_single
            assign s32[i] = vec[32*i + 31];
        end
        for (i = 0; i < MAX_LANES; i++) begin : g_double
            if (i < DBL_LANES) begin : g_live
                assign s64[i] = vec[64*i + 63];
            end else begin : g_pad
                assign s64[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < MAX_LANES; k++) begin
            keep[k] = (k < active_lanes(lane, wide, MAX_LANES));
        end
        signs = ((lane == LANE_64) ? s64 : s32) & keep;
    end
endmodule

// File: rtl/sbt_flag_reg.sv
module sbt_flag_reg
    import sbt_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             illegal,
    input  logic [LANES-1:0] sign_a,
    input  logic [LANES-1:0] sign_b,
    output logic             out_valid,
    output logic             out_fault,
    output flags_t           flags
);
    flags_t next_flags;

    always_comb begin
        next_flags   = '0;
        next_flags.z = ~|(sign_a & sign_b);
        next_flags.c = ~|(~sign_a & sign_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            flags     <= '0;
        end else begin
            out_valid <= take;
            out_fault <= take && illegal;
            if (take && !illegal) begin
                flags <= next_flags;
            end
        end
    end
endmodule

// File: rtl/sign_test_unit.sv
module sign_test_unit
    import sbt_pkg::*;
#(
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [7:0]        opcode,
    input  logic              len_256,
    input  logic              pfx_w,
    input  logic [3:0]        pfx_extra,
    output logic              out_valid,
    output logic              out_fault,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_o,
    output logic              flag_s,
    output logic              flag_a,
    output logic              flag_p
);
    localparam int LANES = DATA_W / 32;

    decode_t          dec;
    logic [LANES-1:0] sign_a;
    logic [LANES-1:0] sign_b;
    flags_t           flags;

    assign in_ready = 1'b1;

    sbt_decode u_decode (
        .opcode    (opcode),
        .pfx_w     (pfx_w),
        .pfx_extra (pfx_extra),
        .dec       (dec)
    );

    sbt_sign_gather #(.DATA_W(DATA_W)) u_gather_a (
        .vec   (src_a),
        .lane  (dec.lane),
        .wide  (len_256),
        .signs (sign_a)
    );

    sbt_sign_gather #(.DATA_W(DATA_W)) u_gather_b (
        .vec   (src_b),
        .lane  (dec.lane),
        .wide  (len_256),
        .signs (sign_b)
    );

    sbt_flag_reg #(.LANES(LANES)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .take      (in_valid && in_ready),
        .illegal   (dec.illegal),
        .sign_a    (sign_a),
        .sign_b    (sign_b),
        .out_valid (out_valid),
        .out_fault (out_fault),
        .flags     (flags)
    );

    assign flag_z = flags.z;
    assign flag_c = flags.c;
    assign flag_o = flags.o;
    assign flag_s = flags.s;
    assign flag_a = flags.a;
    assign flag_p = flags.p;
endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
    parameter int DATA_W = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] src_b,
    input logic [7:0]        opcode,
    input logic              pfx_w,
    input logic [3:0]        pfx_extra,
    input logic              out_valid,
    input logic              out_fault,
    input logic              flag_z,
    input logic              flag_c
);
    logic legal;
    assign legal = !pfx_w && (pfx_extra == 4'b1111) && (opcode == 8'h0E || opcode == 8'h0F);

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_legal_no_fault_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legal) |=> !out_fault);

    assert_w_faults_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pfx_w) |=> out_fault);

    assert_extra_faults_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pfx_extra != 4'b1111) |=> out_fault);

    assert_bad_opcode_faults_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode != 8'h0E && opcode != 8'h0F) |=> out_fault);

    assert_fault_keeps_flags_R5: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> ($stable(flag_z) && $stable(flag_c)));

    assert_empty_b_sets_both_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legal && src_b == '0) |=> (flag_z && flag_c));
endmodule

bind sign_test_unit sbt_checker #(.DATA_W(DATA_W)) u_sbt_checker (.*);

// File: tb/sign_test_unit_test.sv
`timescale 1ns/1ps
module sign_test_unit_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [255:0] src_a;
    logic [255:0] src_b;
    logic [7:0]   opcode;
    logic         len_256;
    logic         pfx_w;
    logic [3:0]   pfx_extra;
    logic         out_valid, out_fault;
    logic         flag_z, flag_c, flag_o, flag_s, flag_a, flag_p;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sign_test_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .src_a(src_a), .src_b(src_b), .opcode(opcode), .len_256(len_256),
        .pfx_w(pfx_w), .pfx_extra(pfx_extra), .out_valid(out_valid),
        .out_fault(out_fault), .flag_z(flag_z), .flag_c(flag_c),
        .flag_o(flag_o), .flag_s(flag_s), .flag_a(flag_a), .flag_p(flag_p)
    );

    task automatic check(input string req, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, actual, expected);
        end
    endtask

    function automatic void model(input logic [255:0] a, input logic [255:0] b,
                                  input logic [7:0] op, input logic wide,
                                  output logic zf, output logic cf);
        int step = (op == 8'h0F) ? 64 : 32;
        int top  = wide ? 256 : 128;
        zf = 1'b1;
        cf = 1'b1;
        for (int k = step - 1; k < top; k += step) begin
            if (a[k] && b[k])  zf = 1'b0;
            if (!a[k] && b[k]) cf = 1'b0;
        end
    endfunction

    // Presents one operation for one cycle and samples after the result edge.
    task automatic issue(input logic [255:0] a, input logic [255:0] b, input logic [7:0] op,
                         input logic wide, input logic w, input logic [3:0] extra);
        @(negedge clk);
        src_a = a; src_b = b; opcode = op; len_256 = wide; pfx_w = w; pfx_extra = extra;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic legal_op(input string req, input logic [255:0] a, input logic [255:0] b,
                            input logic [7:0] op, input logic wide);
        logic zf, cf;
        model(a, b, op, wide, zf, cf);
        issue(a, b, op, wide, 1'b0, 4'hF);
        check({req, " out_valid"}, out_valid, 1'b1);
        check({req, " R8 no fault"}, out_fault, 1'b0);
        check({req, " R2 zf"}, flag_z, zf);
        check({req, " R3 cf"}, flag_c, cf);
        check({req, " R9 other flags"}, flag_o | flag_s | flag_a | flag_p, 1'b0);
    endtask

    // Sets known flags, then issues a faulting op whose operands would change them.
    task automatic fault_op(input string req, input logic [7:0] op, input logic w, input logic [3:0] extra);
        logic [255:0] s31;
        s31 = 256'h0;
        s31[31] = 1'b1;
        legal_op({req, " setup"}, s31, s31, 8'h0E, 1'b1);
        issue(256'h0, s31, op, 1'b1, w, extra);
        check({req, " out_valid"}, out_valid, 1'b1);
        check({req, " fault"}, out_fault, 1'b1);
        check({req, " zf held"}, flag_z, 1'b0);
        check({req, " cf held"}, flag_c, 1'b1);
    endtask

    task automatic test_reset();
        rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0;
        opcode = 8'h0E; len_256 = 1'b0; pfx_w = 1'b0; pfx_extra = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        check("R10 out_valid", out_valid, 1'b0);
        check("R10 fault", out_fault, 1'b0);
        check("R10 flags", flag_z | flag_c | flag_o | flag_s | flag_a | flag_p, 1'b0);
        check("R8 in_ready", in_ready, 1'b1);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_basic_flags();
        logic [255:0] v;
        v = '0; v[31] = 1'b1;
        legal_op("R2 overlap", v, v, 8'h0E, 1'b0);
        legal_op("R3 b only", '0, v, 8'h0E, 1'b0);
        legal_op("R2 a only", v, '0, 8'h0E, 1'b0);
        legal_op("R2 both zero", '0, '0, 8'h0E, 1'b1);
        legal_op("R3 mixed", {8{32'h8000_0000}}, {4{64'h8000_0000_0000_0000}}, 8'h0E, 1'b1);
    endtask

    task automatic test_nonsign_ignored();
        legal_op("R1 low bits", {8{32'h7FFF_FFFF}}, {8{32'h7FFF_FFFF}}, 8'h0E, 1'b1);
        check("R1 zf set", flag_z, 1'b1);
        check("R1 cf set", flag_c, 1'b1);
        legal_op("R1 bit31 in dbl", {8{32'h8000_0000}} & {4{64'h0000_0000_FFFF_FFFF}},
                 {4{64'h0000_0000_8000_0000}}, 8'h0F, 1'b1);
        check("R1 dbl ignores bit31", flag_z, 1'b1);
        legal_op("R1 bit63 in dbl", {4{64'h8000_0000_0000_0000}},
                 {4{64'h8000_0000_0000_0000}}, 8'h0F, 1'b1);
        check("R1 dbl sees bit63", flag_z, 1'b0);
    endtask

    task automatic test_length();
        logic [255:0] v;
        v = '0; v[255] = 1'b1;
        legal_op("R4 narrow single", v, v, 8'h0E, 1'b0);
        check("R4 upper ignored", flag_z, 1'b1);
        legal_op("R4 wide single", v, v, 8'h0E, 1'b1);
        check("R4 upper tested", flag_z, 1'b0);
        legal_op("R4 narrow double", '0, v, 8'h0F, 1'b0);
        check("R4 narrow double cf", flag_c, 1'b1);
        legal_op("R4 wide double", '0, v, 8'h0F, 1'b1);
        check("R4 wide double cf", flag_c, 1'b0);
    endtask

    task automatic test_faults();
        fault_op("R5 w bit", 8'h0E, 1'b1, 4'hF);
        fault_op("R6 extra field", 8'h0F, 1'b0, 4'hE);
        fault_op("R7 opcode", 8'h10, 1'b0, 4'hF);
    endtask

    task automatic test_idle();
        legal_op("R8 before idle", '0, '0, 8'h0E, 1'b0);
        @(posedge clk);
        #1;
        check("R8 idle no valid", out_valid, 1'b0);
    endtask

    initial begin
        test_reset();
        test_basic_flags();
        test_nonsign_ignored();
        test_length();
        test_faults();
        test_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule